// File: doc/BRIEF.md
# Serial Command Slave for a 128-Step Digital Potentiometer

This block is an SPI mode-0 target that gives a host read and write access to the three registers of a 128-position digital potentiometer. There is a live 7-bit position register that sets the wiper. There is a 7-bit power-up position register that is backed by non-volatile storage. There is an 8-bit control register. The serial clock, data-in and active-low select are brought through two-flop synchronizers into the system clock. All frame decoding runs in that clock domain. The data-out line is driven as a value with a separate enable, so that an open-drain pad can be built around it.

A transaction is exactly three bytes, sent most significant bit first. The first byte is a fixed identity byte. The second byte carries a four-bit opcode and a two-bit register selector. The third byte is the write payload, or a filler byte while a read result is shifted out. Writes take effect only when select is released after a complete frame. A write to the power-up register raises a one-cycle strobe toward the non-volatile write sequencer. While that sequencer reports that it is busy, every write is dropped.

All pins are plain level or pulse signals. The serial side is paced only by the host's clock, so no pin carries back-pressure. The strobe toward the sequencer is a one-cycle pulse with no acknowledge, because the busy input already blocks any further write.

Top module: `dpot_spi_slave`

## Requirements
- R1: After reset the wiper code and the power-up code both equal INIT_CODE (default 64). The control register reads VOL=0 and SHDN=1, `pot_on` is 1, and `spi_sdo_oe` is 0.
- R2: The first byte of a frame must be 8'h50. Any other value makes the rest of the frame ignored: no register changes, and `spi_sdo_oe` stays 0 until select has been released.
- R3: The second byte is decoded as follows. Bits 7:4 are the opcode: 4'b1011 is a read and 4'b1100 is a write. Bits 3:2 must be 0. Bits 1:0 select the register: 2'b00 is the position register and 2'b10 is the control register. Any other second byte makes the frame ignored, as in R2.
- R4: Selector 2'b00 reaches the live wiper register when VOL (control bit 7) is 1. It reaches the power-up register when VOL is 0. A write to the live wiper register changes only `wiper_code`.
- R5: A committed write to the power-up register loads the payload bits 6:0 into both the power-up register and `wiper_code`. It also pulses `nv_wr_stb` for exactly one cycle, with `nv_wr_data` equal to the payload.
- R6: A read returns the selected register on SDO, MSB first. Each bit changes after a falling serial clock edge, with the first bit valid before the 17th rising edge. Seven-bit registers read with bit 7 equal to 0. The control register reads as {VOL, SHDN, busy, 5'b00000}, where busy is the `nv_busy` input.
- R7: A write commits only when select rises after 24 bits have been received. A frame released earlier changes nothing. Clock edges after the 24th are ignored.
- R8: While `nv_busy` is 1 when the commit happens, a write to any register is dropped and `nv_wr_stb` does not pulse.
- R9: `spi_sdo_oe` is 1 only during the data byte of a valid read while select is low, and is 0 at all other times.
- R10: A read, including a read of the power-up register, leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least 4 times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock; idles low (mode 0) |
| spi_sdi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low select; frames each transaction |
| spi_sdo | output | 1 | Serial data to the host; 0 when not enabled |
| spi_sdo_oe | output | 1 | Enable for the SDO pad driver |
| nv_busy | input | 1 | Non-volatile write in progress, from the sequencer |
| wiper_code | output | 7 | Live wiper position |
| pot_on | output | 1 | Control SHDN bit; 0 requests shutdown |
| nv_wr_stb | output | 1 | One-cycle request to store `nv_wr_data` |
| nv_wr_data | output | 7 | Value to store in the non-volatile cell |

## Verification
The assertions assume three things about the inputs. The serial clock is slow enough that every level lasts several system cycles. SDI only changes while the serial clock is low. `nv_busy` is steady from the start of a frame until its commit. The stimulus keeps to all three. Each serial half-period lasts eight system cycles. Data and select are changed only while the serial clock is low. The random busy level is chosen between frames, when select is high. Random frames mix valid and corrupted identity bytes, legal and illegal second bytes, and truncated lengths. A directed prologue covers reset, the routing by VOL, the busy lockout and the read layout of the control register.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] ID_CODE = 8'h50;
  localparam logic [3:0] OP_RD = 4'b1011;
  localparam logic [3:0] OP_WR = 4'b1100;
  localparam logic [1:0] SEL_POS = 2'b00;
  localparam logic [1:0] SEL_CTL = 2'b10;

  typedef struct packed {
    logic        vld;
    logic [1:0]  sel;
    logic [7:0]  data;
  } wr_cmd_t;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[i] <= RST_VAL;
      else        pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dpot_frame.sv
module dpot_frame
  import dpot_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       sdi_s,
  input  logic       cs_s,
  input  logic [7:0] rd_word,
  output logic [1:0] peek_sel,
  output wr_cmd_t    wr_cmd,
  output logic       sdo_bit,
  output logic       sdo_oe
);
  localparam int unsigned FRAME_BITS = FRAME_BYTES * BYTE_W;
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_ID = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(2 * BYTE_W);

  logic sck_d, cs_d;
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0] shreg, tx;
  logic [7:0] next_byte;
  logic active, bad, is_rd, is_wr;
  logic [1:0] sel_q;
  logic [3:0] op;
  logic hdr_ok, rd_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;

  assign next_byte = {shreg[6:0], sdi_s};
  assign op        = next_byte[7:4];
  assign peek_sel  = next_byte[1:0];
  assign hdr_ok    = (next_byte[3:2] == 2'b00) && !next_byte[0] &&
                     ((op == OP_RD) || (op == OP_WR));
  assign rd_phase  = is_rd && !bad && (bit_cnt >= CNT_DATA);
  assign sdo_oe    = active && !cs_s && rd_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      tx      <= '0;
      active  <= 1'b0;
      bad     <= 1'b0;
      is_rd   <= 1'b0;
      is_wr   <= 1'b0;
      sel_q   <= '0;
      sdo_bit <= 1'b0;
      wr_cmd  <= '0;
    end else begin
      wr_cmd.vld <= 1'b0;
      if (cs_fall) begin
        active  <= 1'b1;
        bad     <= 1'b0;
        is_rd   <= 1'b0;
        is_wr   <= 1'b0;
        bit_cnt <= '0;
        sdo_bit <= 1'b0;
      end else if (cs_rise) begin
        active <= 1'b0;
        if (active && !bad && is_wr && (bit_cnt == CNT_FULL))
          wr_cmd <= '{vld: 1'b1, sel: sel_q, data: shreg};
      end else if (active && sck_rise && (bit_cnt != CNT_FULL)) begin
        shreg   <= next_byte;
        bit_cnt <= bit_cnt + 1'b1;
        if ((bit_cnt == CNT_ID) && (next_byte != ID_CODE)) bad <= 1'b1;
        if (bit_cnt == CNT_HDR) begin
          if (!hdr_ok) bad <= 1'b1;
          is_rd <= hdr_ok && (op == OP_RD);
          is_wr <= hdr_ok && (op == OP_WR);
          sel_q <= next_byte[1:0];
          tx    <= rd_word;
        end
      end else if (active && sck_fall && rd_phase) begin
        sdo_bit <= tx[7];
        tx      <= {tx[6:0], 1'b0};
      end
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_FULL);

  // R7
  full_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd.vld |-> ($past(bit_cnt) == CNT_FULL) && $past(cs_rise));

  // R2
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bad) && !$past(cs_fall)) |-> !sdo_oe && !wr_cmd.vld);
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int unsigned POS_W = 7,
  parameter logic [POS_W-1:0] INIT_CODE = POS_W'(64)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_cmd_t          wr_cmd,
  input  logic             nv_busy,
  input  logic [1:0]       peek_sel,
  output logic [7:0]       rd_word,
  output logic [POS_W-1:0] wiper,
  output logic             shdn_bit,
  output logic             nv_wr_stb,
  output logic [POS_W-1:0] nv_wr_data
);
  localparam int unsigned PAD_W = BYTE_W - POS_W;
  localparam int unsigned CTL_LOW_W = BYTE_W - 3;

  logic [POS_W-1:0] ivr;
  logic vol;
  logic accept;

  assign accept = wr_cmd.vld && !nv_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper      <= INIT_CODE;
      ivr        <= INIT_CODE;
      vol        <= 1'b0;
      shdn_bit   <= 1'b1;
      nv_wr_stb  <= 1'b0;
      nv_wr_data <= INIT_CODE;
    end else begin
      nv_wr_stb <= 1'b0;
      if (accept) begin
        case (wr_cmd.sel)
          SEL_CTL: begin
            vol      <= wr_cmd.data[7];
            shdn_bit <= wr_cmd.data[6];
          end
          SEL_POS: begin
            wiper <= wr_cmd.data[POS_W-1:0];
            if (!vol) begin
              ivr        <= wr_cmd.data[POS_W-1:0];
              nv_wr_stb  <= 1'b1;
              nv_wr_data <= wr_cmd.data[POS_W-1:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (peek_sel == SEL_CTL)
      rd_word = {vol, shdn_bit, nv_busy, {CTL_LOW_W{1'b0}}};
    else if (vol)
      rd_word = {{PAD_W{1'b0}}, wiper};
    else
      rd_word = {{PAD_W{1'b0}}, ivr};
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nv_busy) |-> $stable(wiper) && $stable(ivr) && $stable(vol) && $stable(shdn_bit));

  // R5
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_stb |=> !nv_wr_stb);

  // R5
  stb_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_stb |-> (wiper == nv_wr_data) && (ivr == nv_wr_data));
endmodule

// File: rtl/dpot_spi_slave.sv
module dpot_spi_slave
  import dpot_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POS_W = 7,
  parameter logic [POS_W-1:0] INIT_CODE = POS_W'(64)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_sdi,
  input  logic             spi_cs_n,
  output logic             spi_sdo,
  output logic             spi_sdo_oe,
  input  logic             nv_busy,
  output logic [POS_W-1:0] wiper_code,
  output logic             pot_on,
  output logic             nv_wr_stb,
  output logic [POS_W-1:0] nv_wr_data
);
  logic [2:0] pins_s;
  logic sck_s, sdi_s, cs_s;
  logic [1:0] peek_sel;
  logic [7:0] rd_word;
  logic sdo_bit;
  wr_cmd_t wr_cmd;

  dpot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({spi_cs_n, spi_sdi, spi_sck}),
    .q       (pins_s)
  );

  assign sck_s = pins_s[0];
  assign sdi_s = pins_s[1];
  assign cs_s  = pins_s[2];

  dpot_frame #(.FRAME_BYTES(3)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .sdi_s    (sdi_s),
    .cs_s     (cs_s),
    .rd_word  (rd_word),
    .peek_sel (peek_sel),
    .wr_cmd   (wr_cmd),
    .sdo_bit  (sdo_bit),
    .sdo_oe   (spi_sdo_oe)
  );

  dpot_regs #(.POS_W(POS_W), .INIT_CODE(INIT_CODE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd     (wr_cmd),
    .nv_busy    (nv_busy),
    .peek_sel   (peek_sel),
    .rd_word    (rd_word),
    .wiper      (wiper_code),
    .shdn_bit   (pot_on),
    .nv_wr_stb  (nv_wr_stb),
    .nv_wr_data (nv_wr_data)
  );

  assign spi_sdo = spi_sdo_oe & sdo_bit;

  // R9
  oe_rise_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sdo_oe) |-> !$past(cs_s));

  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !spi_sdo_oe);
endmodule

// File: tb/dpot_spi_slave_bench.sv
module dpot_spi_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_sdi = 1'b0;
  logic spi_cs_n = 1'b1;
  logic nv_busy = 1'b0;
  logic spi_sdo, spi_sdo_oe, pot_on, nv_wr_stb;
  logic [6:0] wiper_code, nv_wr_data;

  int total = 0;
  int bad = 0;
  int stb_cnt = 0;
  logic [6:0] stb_last = 7'd64;

  // reference state
  logic m_vol = 1'b0;
  logic m_shdn = 1'b1;
  logic [6:0] m_wiper = 7'd64;
  logic [6:0] m_ivr = 7'd64;
  int m_stb = 0;

  always #5 clk = ~clk;

  dpot_spi_slave u_dpot_spi_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sck    (spi_sck),
    .spi_sdi    (spi_sdi),
    .spi_cs_n   (spi_cs_n),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe),
    .nv_busy    (nv_busy),
    .wiper_code (wiper_code),
    .pot_on     (pot_on),
    .nv_wr_stb  (nv_wr_stb),
    .nv_wr_data (nv_wr_data)
  );

  always @(posedge clk) begin
    if (rst_n && nv_wr_stb) begin
      stb_cnt  <= stb_cnt + 1;
      stb_last <= nv_wr_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic hdr_valid(input logic [7:0] ins);
    return (ins == 8'hB0) || (ins == 8'hB2) || (ins == 8'hC0) || (ins == 8'hC2);
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] sel);
    if (sel == 2'b10) return {m_vol, m_shdn, nv_busy, 5'b0};
    else if (m_vol)   return {1'b0, m_wiper};
    else              return {1'b0, m_ivr};
  endfunction

  // drive one frame of nbits bits, collect SDO bits of the data byte
  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input int nbits, output logic [7:0] rd, output int oe_cnt);
    logic [23:0] word;
    word = {b0, b1, b2};
    rd = 8'h00;
    oe_cnt = 0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = word[23-i];
      repeat (8) @(negedge clk);
      if (i >= 16) begin
        rd[23-i] = spi_sdo;
        if (spi_sdo_oe) oe_cnt++;
      end else if (spi_sdo_oe) begin
        oe_cnt++;
      end
      spi_sck = 1'b1;
      repeat (8) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // apply a frame to the model and to the design, then compare
  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input int nbits, input string tag);
    logic [7:0] rd, exp_rd;
    int oe_cnt;
    logic ok, is_rd;
    ok = (nbits == 24) && (b0 == 8'h50) && hdr_valid(b1);
    is_rd = (b0 == 8'h50) && hdr_valid(b1) && (b1[7:4] == 4'b1011);
    exp_rd = exp_read(b1[1:0]);
    xfer(b0, b1, b2, nbits, rd, oe_cnt);
    if (ok && (b1[7:4] == 4'b1100) && !nv_busy) begin
      if (b1[1:0] == 2'b10) begin
        m_vol = b2[7];
        m_shdn = b2[6];
      end else begin
        m_wiper = b2[6:0];
        if (!m_vol) begin
          m_ivr = b2[6:0];
          m_stb++;
        end
      end
    end
    check({tag, " R4 wiper"}, 32'(wiper_code), 32'(m_wiper));
    check({tag, " R8 shdn"}, 32'(pot_on), 32'(m_shdn));
    check({tag, " R5 strobes"}, 32'(stb_cnt), 32'(m_stb));
    if (m_stb > 0) check({tag, " R5 nv data"}, 32'(stb_last), 32'(m_ivr));
    if (is_rd && nbits == 24) begin
      check({tag, " R6 read data"}, 32'(rd), 32'(exp_rd));
      check({tag, " R9 oe in read"}, 32'(oe_cnt), 32'd8);
    end else if (!is_rd) begin
      check({tag, " R2 R3 R9 oe idle"}, 32'(oe_cnt), 32'd0);
    end
    check({tag, " R9 oe after frame"}, 32'(spi_sdo_oe), 32'd0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog run hung actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b0, b1, b2;
    int nb, r;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 wiper", 32'(wiper_code), 32'd64);
    check("R1 pot_on", 32'(pot_on), 32'd1);
    check("R1 oe", 32'(spi_sdo_oe), 32'd0);
    frame(8'h50, 8'hB2, 8'h00, 24, "R1 ctl read");
    frame(8'h50, 8'hB0, 8'h00, 24, "R1 R10 ivr read");
    // R5 power-up register write also moves wiper
    frame(8'h50, 8'hC0, 8'h77, 24, "R5 ivr write");
    // R4 switch to live register and write it
    frame(8'h50, 8'hC2, 8'h80, 24, "R4 vol set");
    frame(8'h50, 8'hC0, 8'h15, 24, "R4 wiper write");
    frame(8'h50, 8'hB0, 8'h00, 24, "R4 wiper read");
    frame(8'h50, 8'hC2, 8'h40, 24, "R4 vol clear");
    frame(8'h50, 8'hB0, 8'hFF, 24, "R10 ivr read");
    // R8 writes dropped while busy, control read shows busy
    nv_busy = 1'b1;
    frame(8'h50, 8'hC0, 8'h22, 24, "R8 busy ivr");
    frame(8'h50, 8'hC2, 8'h00, 24, "R8 busy ctl");
    frame(8'h50, 8'hB2, 8'h00, 24, "R6 busy bit");
    nv_busy = 1'b0;
    // R2 R3 bad headers, R7 short frames
    frame(8'h51, 8'hC0, 8'h01, 24, "R2 bad id");
    frame(8'h50, 8'hC1, 8'h02, 24, "R3 bad sel");
    frame(8'h50, 8'hC4, 8'h03, 24, "R3 bad pad");
    frame(8'h50, 8'hA0, 8'h04, 24, "R3 bad op");
    frame(8'h50, 8'hC0, 8'h05, 23, "R7 short");
    frame(8'h50, 8'hC2, 8'h00, 12, "R7 short hdr");
    frame(8'h50, 8'hC2, 8'h3F, 24, "R8 shdn off");
    for (int k = 0; k < 140; k++) begin
      r = $urandom % 100;
      nv_busy = ($urandom % 5) == 0;
      b0 = (r < 88) ? 8'h50 : 8'($urandom);
      if (r >= 88 && b0 == 8'h50) b0 = 8'h58;
      case ($urandom % 5)
        0: b1 = 8'hB0;
        1: b1 = 8'hB2;
        2: b1 = 8'hC0;
        3: b1 = 8'hC2;
        default: b1 = (($urandom % 2) == 0) ? 8'($urandom) : 8'hC0;
      endcase
      b2 = 8'($urandom);
      nb = (($urandom % 10) == 0) ? int'($urandom % 24) : 24;
      if (nb > 16 && nb < 24 && b1[7:4] == 4'b1011) nb = 16;
      frame(b0, b1, b2, nb, "rand R2 R3 R4 R5 R6 R7 R8 R10");
    end
    nv_busy = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule